// File: doc/BRIEF.md
# Prefixed Instruction Length and Area Classifier

This block sits at the front of an instruction decoder. It takes a candidate instruction as two 32-bit words, the word at the fetch point and the word after it. It reports whether the instruction is 32 or 64 bits long, which encoding area it falls in, and whether it is plain scalar, single-prefixed or vector-prefixed. It also flags reserved patterns and extracts the 24-bit prefix field. A wide decoder can place one copy at every word slot and use the length bit to chain the slots.

Bits are numbered from the most significant end. Bit 0 is the MSB of the first word and bit 32 is the MSB of the second word. The primary opcode is bits 0..5. One opcode value (9) is overloaded as a prefix marker. Bits 30:31, bit 32 and bits 33:37 then choose the sub-area. The classification is combinational. The outputs are registered once, with a valid flag alongside.

Top module: `pfx_len_classify`

## Requirements
- R1: An opcode other than 1 or 9 gives length 32 (out_len64=0), area 0 (standard), mode 0 (scalar), out_rsvd=0 and out_prefix=0, whatever the second word holds.
- R2: Opcode 1 gives length 64, area 3 (long-form), mode 0, out_rsvd=0 and out_prefix=0.
- R3: Opcode 9 with bits 30:31 = 00 gives length 32, area 1 (auxiliary), mode 0 and out_prefix=0, whatever the second word holds.
- R4: Opcode 9 with bits 30:31 = 01 gives length 64 and area 0, with out_prefix equal to bits 6:29. The mode is 0 (scalar) when bits 6:29 are zero, and 1 (single) otherwise.
- R5: Opcode 9 with bits 30:31 = 11 gives length 64, area 0, mode 2 (vector) and out_prefix equal to bits 6:29.
- R6: Opcode 9 with bits 30:31 = 10, bit 32 = 0 and bits 33:37 = 10001 gives area 1 when bits 62:63 are 01 (mode 2). It also gives area 1 when bits 62:63 are 00 and bits 6:29 are nonzero (mode 1).
- R7: In the R6 pattern, bits 62:63 of 10 or 11 give a reserved result: area 4, out_rsvd=1, length 64, mode 0. So do bits 62:63 of 00 with bits 6:29 all zero.
- R8: Opcode 9 with bits 30:31 = 10, outside the R6 pattern and with a second-word opcode (bits 32:37) other than 9, gives area 2 (high). With bit 32 = 1 the mode is 2. With bit 32 = 0 the mode is 0 when bits 6:29 are zero and 1 otherwise.
- R9: Opcode 9 with bits 30:31 = 10 and a second-word opcode of 9 is reserved: area 4, out_rsvd=1, length 64.
- R10: The outputs and out_valid change one clock after a cycle with in_valid=1. When in_valid=0, out_valid falls on the next clock and the classification outputs hold their previous values.
- R11: Reset (rst_n low) clears out_valid and every classification output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate words are valid this cycle |
| word_hi | input | 32 | First instruction word (bits 0..31) |
| word_lo | input | 32 | Following word (bits 32..63) |
| out_valid | output | 1 | Registered results are valid |
| out_len64 | output | 1 | 1 = 64-bit instruction, 0 = 32-bit |
| out_area | output | 3 | Area code (0 std, 1 aux, 2 high, 3 long, 4 reserved) |
| out_mode | output | 2 | Prefix mode (0 scalar, 1 single, 2 vector) |
| out_rsvd | output | 1 | Pattern is reserved |
| out_prefix | output | 24 | Extracted bits 6:29, zero for 32-bit results |

## Verification
The assertions check properties that hold on every cycle. A 32-bit result always carries a zero prefix. Vector mode and reserved results only occur at length 64. The auxiliary area at length 32 is always scalar. The one-cycle valid timing and the hold of the outputs while idle are also checked each cycle. Only the bench's scenarios can show that each bit pattern maps to the right area and mode. They cover the zero-versus-nonzero field splits, every value of bits 62:63, and the overloaded second-word opcode.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   localparam int FIELD_W = 24;

   typedef enum logic [2:0] {
      AREA_STD  = 3'd0,
      AREA_AUX  = 3'd1,
      AREA_HIGH = 3'd2,
      AREA_LONG = 3'd3,
      AREA_RSV  = 3'd4
   } area_e;

   typedef enum logic [1:0] {
      MODE_SCALAR = 2'd0,
      MODE_SINGLE = 2'd1,
      MODE_VECTOR = 2'd2
   } mode_e;

   typedef struct packed {
      logic               len64;
      area_e              area;
      mode_e              mode;
      logic               rsvd;
      logic [FIELD_W-1:0] prefix;
   } cls_t;
endpackage

// File: rtl/pfx_fields.sv
module pfx_fields #(
   parameter int WORD_W  = 32,
   parameter int OP_W    = 6,
   parameter int FIELD_W = 24,
   parameter int SEL_W   = 2
) (
   input  logic [WORD_W-1:0]  word_hi,
   input  logic [WORD_W-1:0]  word_lo,
   output logic [OP_W-1:0]    op1,
   output logic [FIELD_W-1:0] field,
   output logic [SEL_W-1:0]   sel,
   output logic [OP_W-1:0]    op2,
   output logic [SEL_W-1:0]   tail
);
   localparam int OP_LSB  = WORD_W - OP_W;
   localparam int FLD_LSB = SEL_W;

   initial begin
      if (OP_W + FIELD_W + SEL_W != WORD_W)
         $error("pfx_fields: opcode, field and selector must fill one word");
   end

   // MSB-first numbering: instruction bit k maps to word bit WORD_W-1-k
   assign op1   = word_hi[WORD_W-1 -: OP_W];
   assign field = word_hi[FLD_LSB +: FIELD_W];
   assign sel   = word_hi[SEL_W-1:0];
   assign op2   = word_lo[WORD_W-1 -: OP_W];
   assign tail  = word_lo[SEL_W-1:0];

   logic unused_ok;
   assign unused_ok = &{1'b0, word_hi[OP_LSB], 1'b0};
endmodule

// File: rtl/pfx_decode.sv
module pfx_decode
   import pfx_pkg::*;
#(
   parameter int OP_W     = 6,
   parameter int SEL_W    = 2,
   parameter int OP_LONG  = 1,
   parameter int OP_PFX   = 9,
   parameter int OP_AUX2  = 17
) (
   input  logic [OP_W-1:0]    op1,
   input  logic [FIELD_W-1:0] field,
   input  logic [SEL_W-1:0]   sel,
   input  logic [OP_W-1:0]    op2,
   input  logic [SEL_W-1:0]   tail,
   output cls_t               cls
);
   localparam logic [OP_W-1:0] LONG_C = OP_W'(OP_LONG);
   localparam logic [OP_W-1:0] PFX_C  = OP_W'(OP_PFX);
   localparam logic [OP_W-1:0] AUX2_C = OP_W'(OP_AUX2);

   initial begin
      if (SEL_W != 2) $error("pfx_decode: selector must be 2 bits");
      if (OP_LONG == OP_PFX) $error("pfx_decode: opcodes must differ");
   end

   logic fzero;
   assign fzero = (field == '0);

   always_comb begin
      cls        = '0;
      cls.area   = AREA_STD;
      cls.mode   = MODE_SCALAR;
      if (op1 == LONG_C) begin
         cls.len64 = 1'b1;
         cls.area  = AREA_LONG;
      end else if (op1 == PFX_C) begin
         if (sel == 2'b00) begin
            cls.area = AREA_AUX;
         end else begin
            cls.len64  = 1'b1;
            cls.prefix = field;
            unique case (sel)
               2'b01: cls.mode = fzero ? MODE_SCALAR : MODE_SINGLE;
               2'b11: cls.mode = MODE_VECTOR;
               default: begin
                  if (op2 == AUX2_C) begin
                     if (tail == 2'b01) begin
                        cls.area = AREA_AUX;
                        cls.mode = MODE_VECTOR;
                     end else if (tail == 2'b00 && !fzero) begin
                        cls.area = AREA_AUX;
                        cls.mode = MODE_SINGLE;
                     end else begin
                        cls.area = AREA_RSV;
                        cls.rsvd = 1'b1;
                     end
                  end else if (op2 == PFX_C) begin
                     cls.area = AREA_RSV;
                     cls.rsvd = 1'b1;
                  end else begin
                     cls.area = AREA_HIGH;
                     if (op2[OP_W-1])
                        cls.mode = MODE_VECTOR;
                     else
                        cls.mode = fzero ? MODE_SCALAR : MODE_SINGLE;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage
   import pfx_pkg::*;
#(
   parameter bit RESET_DATA = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  cls_t cls_d,
   output logic out_valid,
   output cls_t cls_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   generate
      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)        cls_q <= '0;
            else if (in_valid) cls_q <= cls_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (in_valid) cls_q <= cls_d;
         end
      end
   endgenerate
endmodule

// File: rtl/pfx_len_classify.sv
module pfx_len_classify
   import pfx_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int OP_W       = 6,
   parameter int SEL_W      = 2,
   parameter int OP_LONG    = 1,
   parameter int OP_PFX     = 9,
   parameter int OP_AUX2    = 17,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [WORD_W-1:0]   word_hi,
   input  logic [WORD_W-1:0]   word_lo,
   output logic                out_valid,
   output logic                out_len64,
   output logic [2:0]          out_area,
   output logic [1:0]          out_mode,
   output logic                out_rsvd,
   output logic [FIELD_W-1:0]  out_prefix
);
   initial begin
      if (WORD_W != OP_W + FIELD_W + SEL_W)
         $error("pfx_len_classify: word width mismatch");
      if (!RESET_DATA)
         $error("pfx_len_classify: R11 needs RESET_DATA");
   end

   logic [OP_W-1:0]    op1, op2;
   logic [FIELD_W-1:0] field;
   logic [SEL_W-1:0]   sel, tail;
   cls_t               cls_d, cls_q;

   pfx_fields #(.WORD_W(WORD_W), .OP_W(OP_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_fields (
      .word_hi(word_hi), .word_lo(word_lo),
      .op1(op1), .field(field), .sel(sel), .op2(op2), .tail(tail)
   );

   pfx_decode #(.OP_W(OP_W), .SEL_W(SEL_W), .OP_LONG(OP_LONG),
                .OP_PFX(OP_PFX), .OP_AUX2(OP_AUX2)) u_decode (
      .op1(op1), .field(field), .sel(sel), .op2(op2), .tail(tail), .cls(cls_d)
   );

   pfx_out_stage #(.RESET_DATA(RESET_DATA)) u_stage (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .cls_d(cls_d), .out_valid(out_valid), .cls_q(cls_q)
   );

   assign out_len64  = cls_q.len64;
   assign out_area   = cls_q.area;
   assign out_mode   = cls_q.mode;
   assign out_rsvd   = cls_q.rsvd;
   assign out_prefix = cls_q.prefix;

   // R1
   short_no_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_len64) |-> (out_prefix == '0));
   // R5
   vector_is_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_mode == 2'd2) |-> out_len64);
   // R7
   rsvd_is_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_rsvd) |-> (out_len64 && out_area == 3'd4));
   // R3
   aux_short_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_area == 3'd1 && !out_len64) |-> (out_mode == 2'd0));
   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_area) && $stable(out_prefix)
                     && $stable(out_mode) && $stable(out_len64)));
endmodule

// File: tb/pfx_len_classify_bench.sv
module pfx_len_classify_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] word_hi = '0, word_lo = '0;
   logic        out_valid, out_len64, out_rsvd;
   logic [2:0]  out_area;
   logic [1:0]  out_mode;
   logic [23:0] out_prefix;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pfx_len_classify u_pfx_len_classify (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .word_hi(word_hi), .word_lo(word_lo),
      .out_valid(out_valid), .out_len64(out_len64), .out_area(out_area),
      .out_mode(out_mode), .out_rsvd(out_rsvd), .out_prefix(out_prefix)
   );

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [23:0] f,
                                       input logic [1:0] s);
      return {op, f, s};
   endfunction

   task automatic expect_out(input string req, input logic len, input logic [2:0] area,
                             input logic [1:0] mode, input logic rsvd,
                             input logic [23:0] pfx);
      checks++;
      if (out_valid !== 1'b1 || out_len64 !== len || out_area !== area ||
          out_mode !== mode || out_rsvd !== rsvd || out_prefix !== pfx) begin
         failures++;
         $display("FAIL %s: got v=%b len=%b area=%0d mode=%0d rsvd=%b pfx=%h exp len=%b area=%0d mode=%0d rsvd=%b pfx=%h",
                  req, out_valid, out_len64, out_area, out_mode, out_rsvd, out_prefix,
                  len, area, mode, rsvd, pfx);
      end
   endtask

   task automatic apply(input logic [31:0] hi, input logic [31:0] lo);
      @(negedge clk);
      word_hi = hi; word_lo = lo; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      checks++;
      if (out_valid !== 0 || out_len64 !== 0 || out_area !== 0 || out_mode !== 0 ||
          out_rsvd !== 0 || out_prefix !== 0) begin
         failures++;
         $display("FAIL R11: got v=%b len=%b area=%0d mode=%0d pfx=%h exp all zero",
                  out_valid, out_len64, out_area, out_mode, out_prefix);
      end
   endtask

   task automatic t_plain();
      apply(mk(6'd31, 24'hABCDEF, 2'b11), 32'hFFFF_FFFF);
      expect_out("R1", 0, 0, 0, 0, 24'h0);
      apply(mk(6'd1, 24'h123456, 2'b10), 32'h4400_0002);
      expect_out("R2", 1, 3, 0, 0, 24'h0);
   endtask

   task automatic t_aux32();
      apply(mk(6'd9, 24'h5A5A5A, 2'b00), 32'hDEAD_BEEF);
      expect_out("R3", 0, 1, 0, 0, 24'h0);
   endtask

   task automatic t_std64();
      apply(mk(6'd9, 24'h0, 2'b01), 32'h1234_5678);
      expect_out("R4 zero", 1, 0, 0, 0, 24'h0);
      apply(mk(6'd9, 24'h000100, 2'b01), 32'h1234_5678);
      expect_out("R4 single", 1, 0, 1, 0, 24'h000100);
      apply(mk(6'd9, 24'hC0FFEE, 2'b11), 32'h0);
      expect_out("R5", 1, 0, 2, 0, 24'hC0FFEE);
   endtask

   task automatic t_aux64();
      apply(mk(6'd9, 24'h000001, 2'b10), 32'h4400_0000);
      expect_out("R6 single", 1, 1, 1, 0, 24'h000001);
      apply(mk(6'd9, 24'h0, 2'b10), 32'h4400_0001);
      expect_out("R6 vector", 1, 1, 2, 0, 24'h0);
      apply(mk(6'd9, 24'h0, 2'b10), 32'h4400_0000);
      expect_out("R7 zero", 1, 4, 0, 1, 24'h0);
      apply(mk(6'd9, 24'h777777, 2'b10), 32'h4400_0002);
      expect_out("R7 tail10", 1, 4, 0, 1, 24'h777777);
      apply(mk(6'd9, 24'h777777, 2'b10), 32'h4400_0003);
      expect_out("R7 tail11", 1, 4, 0, 1, 24'h777777);
   endtask

   task automatic t_high();
      apply(mk(6'd9, 24'h0, 2'b10), 32'h8400_0000);
      expect_out("R8 vector", 1, 2, 2, 0, 24'h0);
      apply(mk(6'd9, 24'h0, 2'b10), 32'h0800_0000);
      expect_out("R8 scalar", 1, 2, 0, 0, 24'h0);
      apply(mk(6'd9, 24'h800000, 2'b10), 32'h0800_0000);
      expect_out("R8 single", 1, 2, 1, 0, 24'h800000);
      apply(mk(6'd9, 24'h000010, 2'b10), 32'h2400_0000);
      expect_out("R9", 1, 4, 0, 1, 24'h000010);
   endtask

   task automatic t_hold();
      apply(mk(6'd9, 24'h0000AA, 2'b11), 32'h0);
      expect_out("R10 load", 1, 0, 2, 0, 24'h0000AA);
      @(negedge clk);
      word_hi = mk(6'd1, 24'h0, 2'b00); word_lo = 32'h0; in_valid = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 0 || out_area !== 0 || out_mode !== 2 || out_prefix !== 24'h0000AA) begin
         failures++;
         $display("FAIL R10: got v=%b area=%0d mode=%0d pfx=%h exp v=0 area=0 mode=2 pfx=0000aa",
                  out_valid, out_area, out_mode, out_prefix);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_plain();
      t_aux32();
      t_std64();
      t_aux64();
      t_high();
      t_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule